// File: doc/BRIEF.md
# Blocked Integer Matrix Multiply Sequencer

This block computes C = A × B for a signed integer matrix A of M rows by K columns and a matrix B of K rows by N columns. The three dimensions are given at run time, each from 1 up to 2^DIM_W−1. Both operands and the result live in one internal single-port word RAM. Before a run the RAM is loaded through a test port, and afterwards it is read back the same way. Software must choose sizes that fit, so that M·K + K·N + M·N ≤ 2^ADDR_W.

The work is cut into 2×2 sub-blocks. For each output sub-block, a control state machine steps along the shared dimension one sub-block at a time. For each step it reads four A words and four B words, one word per cycle. A 2×2 multiply-accumulate unit folds each completed operand set into four running sums. The reads for the following sub-block are issued while the unit is consuming the current one, so the unit never stalls the read stream. After the last step, the four sums are written back into the RAM. Operand positions past an odd edge are taken as zero, and result positions past the edge are never written.

Top module: `blkmat_mul`

## Requirements
- R1: After reset, busy_o and done_o are both 0.
- R2: While busy_o is 0 and tp_en_i is 1, the RAM word at tp_addr_i is written with tp_wdata_i when tp_we_i is 1. The word addressed in a cycle appears on tp_rdata_o in the following cycle. Operand words are unchanged by a run.
- R3: Storage is row-major. A[i][k] is at word i·K+k. B[k][j] is at word M·K+k·N+j. C[i][j] is at word 2^ADDR_W−1−(i·N+j).
- R4: Each C[i][j] equals the low DATA_W bits of the sum over k of A[i][k]·B[k][j], with all elements taken as two's-complement signed.
- R5: With odd M, K or N, the missing row or column of an edge sub-block counts as zero. No RAM word outside the C region is written during a run.
- R6: done_o is high for exactly one cycle, in the cycle after the final C write. busy_o falls in that same cycle.
- R7: While busy_o is 1, start_i and the test port have no effect. The run in progress uses its own dimensions and completes normally.
- R8: A start_i with any dimension equal to 0 is ignored, and busy_o stays 0.
- R9: A run keeps busy_o high for exactly ceil(M/2)·ceil(N/2)·(8·ceil(K/2)+6) cycles. This means there are no idle cycles between consecutive sub-block fetches along K.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a run (sampled when idle) |
| m_i | input | DIM_W | Rows of A |
| k_i | input | DIM_W | Shared dimension |
| n_i | input | DIM_W | Columns of B |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| tp_en_i | input | 1 | Test port owns the RAM (idle only) |
| tp_we_i | input | 1 | Test port write enable |
| tp_addr_i | input | ADDR_W | Test port word address |
| tp_wdata_i | input | DATA_W | Test port write data |
| tp_rdata_o | output | DATA_W | RAM read data, one cycle after the address |

## Verification
The bench builds the block with DATA_W=16, DIM_W=3 and ADDR_W=8, which gives a 256-word RAM and dimensions up to 7. With these values it can sweep every M, K, N combination from 1 to 4. Those runs cover every mix of odd and even edges, including 1×1, and each run is checked word by word against the whole RAM. Full-width random operands exercise signed wraparound. A few larger odd and non-square shapes up to 7×7×7 exercise multi-step accumulation along K.

// File: rtl/blkmat_pkg.sv
package blkmat_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DRAIN = 2'd2,
        ST_WRITE = 2'd3
    } bm_state_e;

    // operand slots per sub-block step: 4 from A then 4 from B
    localparam int OPND_SLOTS = 8;
    // result cells per output sub-block
    localparam int CELLS = 4;

endpackage

// File: rtl/blkmat_ram.sv
module blkmat_ram #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[addr_i] <= wdata_i;
        end
        rdata_q <= mem_q[addr_i];
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/blkmat_mac2x2.sv
module blkmat_mac2x2
    import blkmat_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 36
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  go_i,
    input  logic                                  clr_i,
    input  logic [OPND_SLOTS-1:0][DATA_W-1:0]     opnd_i,
    output logic [CELLS-1:0][DATA_W-1:0]          sum_o
);

    function automatic logic signed [ACC_W-1:0] sext(input logic [DATA_W-1:0] v);
        return {{(ACC_W-DATA_W){v[DATA_W-1]}}, v};
    endfunction

    for (genvar r = 0; r < 2; r++) begin : g_row
        for (genvar c = 0; c < 2; c++) begin : g_col
            logic signed [ACC_W-1:0] acc_d, acc_q;
            logic signed [ACC_W-1:0] a0, a1, b0, b1, prod;

            always_comb begin
                a0   = sext(opnd_i[r*2+0]);
                a1   = sext(opnd_i[r*2+1]);
                b0   = sext(opnd_i[4+c]);
                b1   = sext(opnd_i[6+c]);
                prod = a0 * b0 + a1 * b1;
                acc_d = acc_q;
                if (go_i) begin
                    acc_d = clr_i ? prod : acc_q + prod;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    acc_q <= '0;
                end else begin
                    acc_q <= acc_d;
                end
            end

            assign sum_o[r*2+c] = acc_q[DATA_W-1:0];
        end
    end

endmodule

// File: rtl/blkmat_ctrl.sv
module blkmat_ctrl
    import blkmat_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DIM_W  = 4,
    parameter int ADDR_W = 9
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start_i,
    input  logic [DIM_W-1:0]                  m_i,
    input  logic [DIM_W-1:0]                  k_i,
    input  logic [DIM_W-1:0]                  n_i,
    input  logic [DATA_W-1:0]                 ram_rdata_i,
    input  logic [CELLS-1:0][DATA_W-1:0]      sum_i,
    output logic                              busy_o,
    output logic                              done_o,
    output logic                              ram_we_o,
    output logic [ADDR_W-1:0]                 ram_addr_o,
    output logic [DATA_W-1:0]                 ram_wdata_o,
    output logic                              mac_go_o,
    output logic                              mac_clr_o,
    output logic [OPND_SLOTS-1:0][DATA_W-1:0] opnd_o
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(DEPTH - 1);
    localparam logic [ADDR_W-1:0] ONE      = ADDR_W'(1);

    typedef struct packed {
        bm_state_e                        st;
        logic [DIM_W-1:0]                 m;
        logic [DIM_W-1:0]                 k;
        logic [DIM_W-1:0]                 n;
        logic [DIM_W-1:0]                 ib;
        logic [DIM_W-1:0]                 jb;
        logic [DIM_W-1:0]                 kb;
        logic [2:0]                       cnt;
        logic                             cap_vld;
        logic [2:0]                       cap_slot;
        logic                             cap_pad;
        logic                             cap_first;
        logic [OPND_SLOTS-1:0][DATA_W-1:0] opnd;
        logic                             go;
        logic                             go_clr;
        logic                             done;
    } ctrl_s;

    ctrl_s s_d, s_q;

    logic [ADDR_W-1:0] mw, kw, nw, mblk, kblk, nblk;
    logic [ADDR_W-1:0] ibw, jbw, kbw;
    logic [ADDR_W-1:0] f_row, f_col, rd_addr;
    logic [ADDR_W-1:0] w_row, w_col, wr_addr;
    logic              rd_pad, wr_ok;
    logic              last_kb, last_jb, last_ib;

    // address generation
    always_comb begin
        mw   = ADDR_W'(s_q.m);
        kw   = ADDR_W'(s_q.k);
        nw   = ADDR_W'(s_q.n);
        mblk = (mw + ONE) >> 1;
        kblk = (kw + ONE) >> 1;
        nblk = (nw + ONE) >> 1;
        ibw  = ADDR_W'(s_q.ib) << 1;
        jbw  = ADDR_W'(s_q.jb) << 1;
        kbw  = ADDR_W'(s_q.kb) << 1;

        last_kb = (ADDR_W'(s_q.kb) == kblk - ONE);
        last_jb = (ADDR_W'(s_q.jb) == nblk - ONE);
        last_ib = (ADDR_W'(s_q.ib) == mblk - ONE);

        if (!s_q.cnt[2]) begin
            // slots 0..3: A sub-block
            f_row   = ibw + ADDR_W'(s_q.cnt[1]);
            f_col   = kbw + ADDR_W'(s_q.cnt[0]);
            rd_pad  = (f_row >= mw) || (f_col >= kw);
            rd_addr = f_row * kw + f_col;
        end else begin
            // slots 4..7: B sub-block
            f_row   = kbw + ADDR_W'(s_q.cnt[1]);
            f_col   = jbw + ADDR_W'(s_q.cnt[0]);
            rd_pad  = (f_row >= kw) || (f_col >= nw);
            rd_addr = mw * kw + f_row * nw + f_col;
        end

        w_row   = ibw + ADDR_W'(s_q.cnt[1]);
        w_col   = jbw + ADDR_W'(s_q.cnt[0]);
        wr_ok   = (w_row < mw) && (w_col < nw);
        wr_addr = TOP_ADDR - (w_row * nw + w_col);
    end

    // next-state
    always_comb begin
        s_d         = s_q;
        s_d.go      = 1'b0;
        s_d.done    = 1'b0;
        s_d.cap_vld = 1'b0;

        ram_we_o    = 1'b0;
        ram_addr_o  = rd_addr;
        ram_wdata_o = sum_i[s_q.cnt[1:0]];

        // returning read data lands one cycle after its address
        if (s_q.cap_vld) begin
            s_d.opnd[s_q.cap_slot] = s_q.cap_pad ? '0 : ram_rdata_i;
            if (s_q.cap_slot == 3'd7) begin
                s_d.go     = 1'b1;
                s_d.go_clr = s_q.cap_first;
            end
        end

        unique case (s_q.st)
            ST_IDLE: begin
                if (start_i && (m_i != '0) && (k_i != '0) && (n_i != '0)) begin
                    s_d.st  = ST_FETCH;
                    s_d.m   = m_i;
                    s_d.k   = k_i;
                    s_d.n   = n_i;
                    s_d.ib  = '0;
                    s_d.jb  = '0;
                    s_d.kb  = '0;
                    s_d.cnt = '0;
                end
            end

            ST_FETCH: begin
                s_d.cap_vld   = 1'b1;
                s_d.cap_slot  = s_q.cnt;
                s_d.cap_pad   = rd_pad;
                s_d.cap_first = (s_q.kb == '0);
                s_d.cnt       = s_q.cnt + 3'd1;
                if (s_q.cnt == 3'd7) begin
                    if (last_kb) begin
                        s_d.st = ST_DRAIN;
                        s_d.kb = '0;
                    end else begin
                        s_d.kb = s_q.kb + 1'b1;
                    end
                end
            end

            ST_DRAIN: begin
                // leave once the final multiply-accumulate is issued
                if (s_q.go) begin
                    s_d.st  = ST_WRITE;
                    s_d.cnt = '0;
                end
            end

            ST_WRITE: begin
                ram_addr_o = wr_addr;
                ram_we_o   = wr_ok;
                s_d.cnt    = s_q.cnt + 3'd1;
                if (s_q.cnt == 3'd3) begin
                    s_d.cnt = '0;
                    s_d.st  = ST_FETCH;
                    if (last_jb) begin
                        s_d.jb = '0;
                        if (last_ib) begin
                            s_d.st   = ST_IDLE;
                            s_d.done = 1'b1;
                        end else begin
                            s_d.ib = s_q.ib + 1'b1;
                        end
                    end else begin
                        s_d.jb = s_q.jb + 1'b1;
                    end
                end
            end

            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o    = (s_q.st != ST_IDLE);
    assign done_o    = s_q.done;
    assign mac_go_o  = s_q.go;
    assign mac_clr_o = s_q.go_clr;
    assign opnd_o    = s_q.opnd;

endmodule

// File: rtl/blkmat_mul.sv
module blkmat_mul
    import blkmat_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DIM_W  = 4,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DIM_W-1:0]  m_i,
    input  logic [DIM_W-1:0]  k_i,
    input  logic [DIM_W-1:0]  n_i,
    output logic              busy_o,
    output logic              done_o,
    input  logic              tp_en_i,
    input  logic              tp_we_i,
    input  logic [ADDR_W-1:0] tp_addr_i,
    input  logic [DATA_W-1:0] tp_wdata_i,
    output logic [DATA_W-1:0] tp_rdata_o
);
    localparam int ACC_W = 2 * DATA_W + 4;

    logic                              c_we;
    logic [ADDR_W-1:0]                 c_addr;
    logic [DATA_W-1:0]                 c_wdata;
    logic                              ram_we;
    logic [ADDR_W-1:0]                 ram_addr;
    logic [DATA_W-1:0]                 ram_wdata;
    logic [DATA_W-1:0]                 ram_rdata;
    logic                              mac_go, mac_clr;
    logic [OPND_SLOTS-1:0][DATA_W-1:0] opnd;
    logic [CELLS-1:0][DATA_W-1:0]      sums;
    logic                              tp_sel;

    blkmat_ctrl #(
        .DATA_W (DATA_W),
        .DIM_W  (DIM_W),
        .ADDR_W (ADDR_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .m_i         (m_i),
        .k_i         (k_i),
        .n_i         (n_i),
        .ram_rdata_i (ram_rdata),
        .sum_i       (sums),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .ram_we_o    (c_we),
        .ram_addr_o  (c_addr),
        .ram_wdata_o (c_wdata),
        .mac_go_o    (mac_go),
        .mac_clr_o   (mac_clr),
        .opnd_o      (opnd)
    );

    blkmat_mac2x2 #(
        .DATA_W (DATA_W),
        .ACC_W  (ACC_W)
    ) u_mac (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (mac_go),
        .clr_i  (mac_clr),
        .opnd_i (opnd),
        .sum_o  (sums)
    );

    // test port owns the RAM only while no run is in progress
    always_comb begin
        tp_sel    = tp_en_i && !busy_o;
        ram_we    = tp_sel ? tp_we_i    : c_we;
        ram_addr  = tp_sel ? tp_addr_i  : c_addr;
        ram_wdata = tp_sel ? tp_wdata_i : c_wdata;
    end

    blkmat_ram #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_ram (
        .clk     (clk),
        .we_i    (ram_we),
        .addr_i  (ram_addr),
        .wdata_i (ram_wdata),
        .rdata_o (ram_rdata)
    );

    assign tp_rdata_o = ram_rdata;

endmodule

// File: rtl/blkmat_chk.sv
module blkmat_chk #(
    parameter int DIM_W  = 4,
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [DIM_W-1:0]  m_i,
    input logic [DIM_W-1:0]  k_i,
    input logic [DIM_W-1:0]  n_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              ram_we,
    input logic [ADDR_W-1:0] ram_addr
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DIM_W-1:0] m_l, n_l;
    logic [ADDR_W:0]  c_low;
    logic             zero_dim;

    assign zero_dim = (m_i == '0) || (k_i == '0) || (n_i == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_l <= '0;
            n_l <= '0;
        end else if (!busy_o && start_i && !zero_dim) begin
            m_l <= m_i;
            n_l <= n_i;
        end
    end

    assign c_low = (ADDR_W+1)'(DEPTH) - (ADDR_W+1)'(m_l) * (ADDR_W+1)'(n_l);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_busy_ends_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    assert_zero_dim_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && zero_dim) |=> !busy_o);

    assert_write_in_c_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && ram_we) |-> ({1'b0, ram_addr} >= c_low));

endmodule

bind blkmat_mul blkmat_chk #(
    .DIM_W  (DIM_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .m_i      (m_i),
    .k_i      (k_i),
    .n_i      (n_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .ram_we   (ram_we),
    .ram_addr (ram_addr)
);

// File: tb/blkmat_mul_tb.sv
`timescale 1ns/1ps
module blkmat_mul_tb;
    localparam int DATA_W = 16;
    localparam int DIM_W  = 3;
    localparam int ADDR_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [DIM_W-1:0]  m_i = '0, k_i = '0, n_i = '0;
    logic              busy_o, done_o;
    logic              tp_en_i = 1'b0, tp_we_i = 1'b0;
    logic [ADDR_W-1:0] tp_addr_i = '0;
    logic [DATA_W-1:0] tp_wdata_i = '0;
    logic [DATA_W-1:0] tp_rdata_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [DATA_W-1:0] exp_mem [DEPTH];

    always #2.5 clk = ~clk;

    blkmat_mul #(.DATA_W(DATA_W), .DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .m_i(m_i), .k_i(k_i), .n_i(n_i),
        .busy_o(busy_o), .done_o(done_o),
        .tp_en_i(tp_en_i), .tp_we_i(tp_we_i), .tp_addr_i(tp_addr_i),
        .tp_wdata_i(tp_wdata_i), .tp_rdata_o(tp_rdata_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic preload(input int m, input int k, input int n);
        for (int a = 0; a < DEPTH; a++) exp_mem[a] = DATA_W'($urandom);
        for (int i = 0; i < m; i++) begin
            for (int j = 0; j < n; j++) begin
                int s = 0;
                for (int kk = 0; kk < k; kk++)
                    s += int'($signed(exp_mem[i*k+kk])) * int'($signed(exp_mem[m*k+kk*n+j]));
                exp_mem[DEPTH-1-(i*n+j)] = DATA_W'(s);
            end
        end
        // C area is preloaded with junk; the run must overwrite it
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk);
            tp_en_i = 1'b1; tp_we_i = 1'b1;
            tp_addr_i = ADDR_W'(a);
            tp_wdata_i = (a >= DEPTH - m*n) ? ~exp_mem[a] : exp_mem[a];
        end
        @(negedge clk);
        tp_en_i = 1'b0; tp_we_i = 1'b0;
    endtask

    task automatic readback(input int m, input int k, input int n);
        @(negedge clk);
        tp_en_i = 1'b1; tp_we_i = 1'b0; tp_addr_i = '0;
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk);
            if (a >= DEPTH - m*n)
                chk(tp_rdata_o == exp_mem[a], "R3,R4 C word", int'(tp_rdata_o), int'(exp_mem[a]));
            else if (a < m*k + k*n)
                chk(tp_rdata_o == exp_mem[a], "R2 operand word", int'(tp_rdata_o), int'(exp_mem[a]));
            else
                chk(tp_rdata_o == exp_mem[a], "R5 untouched word", int'(tp_rdata_o), int'(exp_mem[a]));
            if (a < DEPTH-1) tp_addr_i = ADDR_W'(a + 1);
        end
        tp_en_i = 1'b0;
    endtask

    task automatic run_case(input int m, input int k, input int n, input bit disturb);
        int cyc = 0;
        bit seen = 0;
        int expc = ((m+1)/2) * ((n+1)/2) * (8*((k+1)/2) + 6);
        preload(m, k, n);
        @(negedge clk);
        start_i = 1'b1;
        m_i = DIM_W'(m); k_i = DIM_W'(k); n_i = DIM_W'(n);
        for (int t = 0; t < 4000; t++) begin
            @(negedge clk);
            if (done_o) begin
                seen = 1;
                chk(!busy_o, "R6 busy low with done", int'(busy_o), 0);
                break;
            end
            if (busy_o) cyc++;
            start_i = 1'b0; tp_en_i = 1'b0; tp_we_i = 1'b0;
            if (disturb && cyc == 5) begin
                // R7: new start and a test-port write during the run
                start_i = 1'b1;
                m_i = 3'd4; k_i = 3'd4; n_i = 3'd4;
                tp_en_i = 1'b1; tp_we_i = 1'b1;
                tp_addr_i = '0; tp_wdata_i = ~exp_mem[0];
            end
        end
        chk(seen, "R6 done seen", int'(seen), 1);
        chk(cyc == expc, disturb ? "R7 busy length" : "R9 busy length", cyc, expc);
        @(negedge clk);
        chk(!done_o, "R6 done single cycle", int'(done_o), 0);
        readback(m, k, n);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy_o, "R1 busy after reset", int'(busy_o), 0);
        chk(!done_o, "R1 done after reset", int'(done_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !done_o, "R1 idle after release", int'({busy_o, done_o}), 0);

        // R2: direct write then read through the test port
        tp_en_i = 1'b1; tp_we_i = 1'b1; tp_addr_i = 8'd17; tp_wdata_i = 16'hA5C3;
        @(negedge clk);
        tp_we_i = 1'b0;
        @(negedge clk);
        chk(tp_rdata_o == 16'hA5C3, "R2 test port readback", int'(tp_rdata_o), 'hA5C3);
        tp_en_i = 1'b0;

        // R8: zero dimension start ignored
        @(negedge clk);
        start_i = 1'b1; m_i = 3'd2; k_i = 3'd0; n_i = 3'd2;
        @(negedge clk);
        start_i = 1'b0;
        chk(!busy_o, "R8 zero k ignored", int'(busy_o), 0);
        @(negedge clk);
        chk(!busy_o && !done_o, "R8 still idle", int'({busy_o, done_o}), 0);

        for (int m = 1; m <= 4; m++)
            for (int k = 1; k <= 4; k++)
                for (int n = 1; n <= 4; n++)
                    run_case(m, k, n, 1'b0);
        run_case(7, 7, 7, 1'b0);
        run_case(5, 3, 7, 1'b0);
        run_case(7, 1, 2, 1'b0);
        run_case(3, 3, 2, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule